// File: doc/BRIEF.md
# I2C Addressed Transfer Sequencer

This block runs a whole addressed I2C transfer on its own. It drives a master controller that reports each bus step as a status code, and it reaches that controller only through the controller's register port. A client loads the device address, the number of memory address bytes, the byte count and the operation, then pulses `start`. The sequencer issues each step and polls the controller's interrupt flag. It compares the status code against the value each step should produce. A mismatch or a silent controller ends the transfer early.

There are three operations. A write sends the memory address bytes and then data bytes taken from a valid/ready input stream. A read sends the memory address bytes, turns the bus round with a repeated START and collects the requested bytes on a valid output. A probe addresses the device for reading and takes one byte that it does not acknowledge. A STOP closes every transfer, including one that failed. When the transfer ends, a one-cycle `done` pulse presents a 32-bit result word. The word is zero on success. Otherwise it packs an error class with the last control value, the last status value and the status that was expected.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset, `busy`, `done`, `reg_wr`, `reg_rd`, `in_ready` and `out_valid` are all low.
- R2: A write (op 0) issues START (expects 0x08), then sends the device address with bit 0 clear (expects 0x18). It sends `alen_m1`+1 memory address bytes, most significant first, and then `count` bytes from the input stream, each expecting 0x28. It then issues STOP and returns result 0.
- R3: A read (op 1) sends the same START, device address and memory address bytes as a write. It then issues a repeated START with no STOP in between (expects 0x10) and sends the device address with bit 0 set (expects 0x40). Finally it receives `count` bytes and presents each one on `out_valid`/`out_data`.
- R4: A probe (op 2 or 3) issues START and sends the device address with bit 0 set. It receives exactly one byte with acknowledge off (expects 0x58), issues STOP and sends no memory address byte.
- R5: After each control write the sequencer reads the control register every `POLL_GAP` cycles until bit 3 (interrupt flag) is set. It makes at most `POLL_MAX` such reads.
- R6: When the flag is set and the status register differs from the expected code, the transfer aborts. The result is {8'h01, last control read, status read, expected code}.
- R7: When the flag stays low for all `POLL_MAX` reads, the sequencer reads status once and aborts. The result is {8'h02, last control read, that status, expected code}.
- R8: STOP (control 0x50) is written once at the end of every transfer, including after an error. If no error came earlier and the status register does not show 0xF8 within `POLL_MAX` reads, the sequencer reads control once. The result is then {8'h02, that control, last status read, 8'hF8}.
- R9: `busy` rises the cycle after an accepted `start` and stays high through the cycle in which `done` is high. `done` lasts exactly one cycle, and `result` is valid with it.
- R10: Register offsets are 0 for data, 1 for control and 2 for status. Control bits are 0x40 (enable), 0x20 (START), 0x10 (STOP), 0x08 (interrupt flag) and 0x04 (acknowledge). Acknowledge is set for every received byte but the last, so the status codes are 0x50 and then 0x58.
- R11: `reg_wr` and `reg_rd` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| op | input | 2 | 0 write, 1 read, 2 or 3 probe |
| dev_addr | input | 7 | Target device address |
| mem_addr | input | 32 | Memory address, low bytes used |
| alen_m1 | input | 2 | Number of memory address bytes minus one |
| count | input | CNT_W | Data bytes to send or receive |
| in_data | input | 8 | Write data stream byte |
| in_valid | input | 1 | Write data byte available |
| in_ready | output | 1 | Write data byte taken this cycle |
| out_data | output | 8 | Received byte |
| out_valid | output | 1 | Received byte strobe |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| result | output | 32 | Zero or packed diagnostic word |
| reg_wr | output | 1 | Controller register write strobe |
| reg_rd | output | 1 | Controller register read strobe |
| reg_addr | output | 2 | Controller register offset |
| reg_wdata | output | 8 | Controller register write data |
| reg_rdata | input | 8 | Controller register read data, valid in the cycle of `reg_rd` |

## Verification
The assertions assume two things. First, `reg_rdata` answers a read combinationally in the same cycle. Second, `start` and the transfer parameters are only meaningful while `busy` is low. The bench's controller model serves every register read from its own state in the same cycle. The bench pulses `start` only between transfers and holds the operands steady until `done`. The model sets the interrupt flag a fixed few cycles after each control write, well inside the polling window. The only exception is the test that deliberately keeps the controller silent.

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq #(
  parameter int POLL_MAX = 1000,
  parameter int POLL_GAP = 4,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [6:0]       dev_addr,
  input  logic [31:0]      mem_addr,
  input  logic [1:0]       alen_m1,
  input  logic [CNT_W-1:0] count,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [7:0]       out_data,
  output logic             out_valid,
  output logic             busy,
  output logic             done,
  output logic [31:0]      result,
  output logic             reg_wr,
  output logic             reg_rd,
  output logic [1:0]       reg_addr,
  output logic [7:0]       reg_wdata,
  input  logic [7:0]       reg_rdata
);
  localparam int TW = $clog2(POLL_MAX + 1);
  localparam int GW = $clog2(POLL_GAP + 1);

  localparam logic [7:0] C_EN = 8'h40, C_STA = 8'h20, C_STO = 8'h10, C_ACK = 8'h04;
  localparam logic [7:0] S_BEG = 8'h08, S_RBEG = 8'h10, S_AW = 8'h18, S_DW = 8'h28;
  localparam logic [7:0] S_AR = 8'h40, S_RACK = 8'h50, S_RNAK = 8'h58, S_IDL = 8'hF8;
  localparam logic [1:0] A_DATA = 2'd0, A_CTRL = 2'd1, A_STAT = 2'd2;

  typedef enum logic [3:0] {
    IDLE, STEP, GETB, WDAT, WCTL, GAP, RCTL, RSTA, RDAT, STOPW, SGAP, SPOLL, SCTL, FIN
  } st_t;
  typedef enum logic [2:0] {
    P_START, P_DEV, P_MADDR, P_RST, P_DEVR, P_RECV, P_WDATA, P_STOP
  } ph_t;

  st_t              st;
  ph_t              ph;
  logic             rd_q, probe_q, tmo_q, err_q;
  logic [6:0]       dev_q;
  logic [31:0]      maddr_q;
  logic [1:0]       am1_q;
  logic [CNT_W-1:0] cnt_q, idx;
  logic [7:0]       byte_q, exp_q, ctl_q, last_ctrl, last_stat;
  logic [TW-1:0]    tries;
  logic [GW-1:0]    gap;
  logic [31:0]      res_q;

  wire [CNT_W-1:0] idx_nx  = idx + 1'b1;
  wire             last_rx = (idx_nx == cnt_q);
  wire [4:0]       sh      = {am1_q - idx[1:0], 3'b000};
  wire [31:0]      mshift  = maddr_q >> sh;
  wire             gap_end = (gap == GW'(POLL_GAP - 1));
  wire             try_end = (tries == TW'(POLL_MAX - 1));

  assign busy      = (st != IDLE);
  assign done      = (st == FIN);
  assign result    = res_q;
  assign in_ready  = (st == GETB);
  assign out_valid = (st == RDAT);
  assign out_data  = reg_rdata;

  always_comb begin
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = A_DATA; reg_wdata = 8'h00;
    case (st)
      WDAT:  begin reg_wr = 1'b1; reg_addr = A_DATA; reg_wdata = byte_q; end
      WCTL:  begin reg_wr = 1'b1; reg_addr = A_CTRL; reg_wdata = ctl_q; end
      STOPW: begin reg_wr = 1'b1; reg_addr = A_CTRL; reg_wdata = C_EN | C_STO; end
      RCTL, SCTL:  begin reg_rd = 1'b1; reg_addr = A_CTRL; end
      RSTA, SPOLL: begin reg_rd = 1'b1; reg_addr = A_STAT; end
      RDAT:  begin reg_rd = 1'b1; reg_addr = A_DATA; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; ph <= P_START; rd_q <= 1'b0; probe_q <= 1'b0; tmo_q <= 1'b0; err_q <= 1'b0;
      dev_q <= '0; maddr_q <= '0; am1_q <= '0; cnt_q <= '0; idx <= '0;
      byte_q <= '0; exp_q <= '0; ctl_q <= '0; last_ctrl <= '0; last_stat <= '0;
      tries <= '0; gap <= '0; res_q <= '0;
    end else begin
      case (st)
        IDLE: if (start) begin
          probe_q <= op[1];
          rd_q    <= (op == 2'd1);
          dev_q   <= dev_addr;
          maddr_q <= mem_addr;
          am1_q   <= alen_m1;
          cnt_q   <= op[1] ? CNT_W'(1) : count;
          ph      <= P_START;
          idx     <= '0;
          res_q   <= '0;
          err_q   <= 1'b0;
          st      <= STEP;
        end
        STEP: begin
          ctl_q <= C_EN;
          case (ph)
            P_START: begin ctl_q <= C_EN | C_STA; exp_q <= S_BEG; st <= WCTL; end
            P_DEV:   begin byte_q <= {dev_q, probe_q}; exp_q <= probe_q ? S_AR : S_AW; st <= WDAT; end
            P_MADDR: begin byte_q <= mshift[7:0]; exp_q <= S_DW; st <= WDAT; end
            P_RST:   begin ctl_q <= C_EN | C_STA; exp_q <= S_RBEG; st <= WCTL; end
            P_DEVR:  begin byte_q <= {dev_q, 1'b1}; exp_q <= S_AR; st <= WDAT; end
            P_RECV:
              if (idx == cnt_q) st <= STOPW;
              else begin
                ctl_q <= last_rx ? C_EN : (C_EN | C_ACK);
                exp_q <= last_rx ? S_RNAK : S_RACK;
                st    <= WCTL;
              end
            P_WDATA:
              if (idx == cnt_q) st <= STOPW;
              else begin exp_q <= S_DW; st <= GETB; end
            default: st <= STOPW;
          endcase
        end
        GETB: if (in_valid) begin byte_q <= in_data; st <= WDAT; end
        WDAT: st <= WCTL;
        WCTL: begin tries <= '0; gap <= '0; st <= GAP; end
        GAP:  if (gap_end) st <= RCTL; else gap <= gap + 1'b1;
        RCTL: begin
          last_ctrl <= reg_rdata;
          if (reg_rdata[3]) begin tmo_q <= 1'b0; st <= RSTA; end
          else if (try_end) begin tmo_q <= 1'b1; st <= RSTA; end
          else begin tries <= tries + 1'b1; gap <= '0; st <= GAP; end
        end
        RSTA: begin
          last_stat <= reg_rdata;
          if (tmo_q) begin
            res_q <= {8'h02, last_ctrl, reg_rdata, exp_q}; err_q <= 1'b1; st <= STOPW;
          end else if (reg_rdata != exp_q) begin
            res_q <= {8'h01, last_ctrl, reg_rdata, exp_q}; err_q <= 1'b1; st <= STOPW;
          end else if (ph == P_RECV) begin
            st <= RDAT;
          end else begin
            st <= STEP;
            case (ph)
              P_START: ph <= P_DEV;
              P_DEV:   ph <= probe_q ? P_RECV : P_MADDR;
              P_MADDR:
                if (idx[1:0] == am1_q) begin ph <= rd_q ? P_RST : P_WDATA; idx <= '0; end
                else idx <= idx_nx;
              P_RST:   ph <= P_DEVR;
              P_DEVR:  ph <= P_RECV;
              P_WDATA: idx <= idx_nx;
              default: ph <= P_STOP;
            endcase
          end
        end
        RDAT:  begin idx <= idx_nx; st <= STEP; end
        STOPW: begin tries <= '0; gap <= '0; st <= SGAP; end
        SGAP:  if (gap_end) st <= SPOLL; else gap <= gap + 1'b1;
        SPOLL: begin
          last_stat <= reg_rdata;
          if (reg_rdata == S_IDL) st <= FIN;
          else if (try_end) st <= err_q ? FIN : SCTL;
          else begin tries <= tries + 1'b1; gap <= '0; st <= SGAP; end
        end
        SCTL: begin res_q <= {8'h02, reg_rdata, last_stat, S_IDL}; st <= FIN; end
        FIN:  st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  a_r11_excl_access: assert property (@(posedge clk) disable iff (!rst_n) !(reg_wr && reg_rd));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> !busy);
  a_r9_busy_to_done: assert property (@(posedge clk) disable iff (!rst_n) (busy && !done) |=> busy);
  a_r7_class_range: assert property (@(posedge clk) disable iff (!rst_n) done |-> (result[31:24] <= 8'd2));
  a_r3_rx_in_xfer: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (busy && reg_rd));
  a_r8_stop_before_done: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(reg_rd));
endmodule

// File: tb/sim_i2c_xfer_seq.sv
module sim_i2c_xfer_seq;
  localparam int CLK_PERIOD = 10;
  localparam int PMAX = 6;
  localparam int PGAP = 2;
  localparam int LAT  = 3;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] op = 2'd0, alen_m1 = 2'd0;
  logic [6:0] dev_addr = DEV;
  logic [31:0] mem_addr = 32'h0;
  logic [7:0] count = 8'd0;
  logic [7:0] in_data, out_data, reg_wdata, reg_rdata;
  logic in_valid, in_ready, out_valid, busy, done, reg_wr, reg_rd;
  logic [1:0] reg_addr;
  logic [31:0] result;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_xfer_seq #(.POLL_MAX(PMAX), .POLL_GAP(PGAP), .CNT_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .dev_addr(dev_addr),
    .mem_addr(mem_addr), .alen_m1(alen_m1), .count(count), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .busy(busy), .done(done), .result(result), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  int checks = 0, errors = 0;

  function automatic logic [7:0] txg(int j); return 8'hC1 ^ 8'(j * 29); endfunction
  function automatic logic [7:0] rxg(int k); return 8'h3C + 8'(k * 17); endfunction

  int tj = 0;
  assign in_valid = 1'b1;
  assign in_data  = txg(tj);
  always @(posedge clk) if (in_valid && in_ready) tj <= tj + 1;

  // controller model
  logic m_iflg = 1'b0, m_started = 1'b0, m_anext = 1'b0, m_rd = 1'b0;
  logic [7:0] m_stat = 8'hF8, m_ctrl = 8'h00, m_data = 8'h00;
  int m_cnt = 0, m_kind = 0, m_k = 0;
  logic mute = 1'b0, noidle = 1'b0;
  logic [7:0] wlog [512];
  logic acklog [512];
  int wn = 0, an = 0, stops = 0, rstarts = 0;

  assign reg_rdata = (reg_addr == 2'd0) ? m_data :
                     (reg_addr == 2'd1) ? (m_ctrl | {4'b0, m_iflg, 3'b0}) : m_stat;

  always @(posedge clk) begin
    if (reg_wr && reg_addr == 2'd0) m_data <= reg_wdata;
    if (reg_wr && reg_addr == 2'd1) begin
      m_ctrl <= reg_wdata & ~8'h30;
      m_iflg <= 1'b0;
      m_kind <= reg_wdata[4] ? 2 : (reg_wdata[5] ? 1 : 3);
      m_cnt  <= LAT;
    end else if (m_cnt > 0) begin
      m_cnt <= m_cnt - 1;
      if (m_cnt == 1) begin
        case (m_kind)
          1: begin
            m_stat <= mute ? m_stat : (m_started ? 8'h10 : 8'h08);
            if (m_started) rstarts <= rstarts + 1;
            m_started <= 1'b1; m_anext <= 1'b1; m_k <= 0;
            m_iflg <= !mute;
          end
          2: begin
            if (!noidle) m_stat <= 8'hF8;
            m_started <= 1'b0; stops <= stops + 1;
          end
          default: begin
            m_iflg <= 1'b1;
            if (m_anext) begin
              wlog[wn] <= m_data; wn <= wn + 1;
              m_anext <= 1'b0; m_rd <= m_data[0];
              if (m_data[0]) m_stat <= (m_data[7:1] == DEV) ? 8'h40 : 8'h48;
              else           m_stat <= (m_data[7:1] == DEV) ? 8'h18 : 8'h20;
            end else if (m_rd) begin
              m_data <= rxg(m_k); m_k <= m_k + 1;
              acklog[an] <= m_ctrl[2]; an <= an + 1;
              m_stat <= m_ctrl[2] ? 8'h50 : 8'h58;
            end else begin
              wlog[wn] <= m_data; wn <= wn + 1; m_stat <= 8'h28;
            end
          end
        endcase
      end
    end
  end

  logic [7:0] rxlog [512];
  int rn = 0, nctl = 0, nboth = 0;
  always @(negedge clk) begin
    if (out_valid) begin rxlog[rn] = out_data; rn = rn + 1; end
    if (reg_rd && reg_addr == 2'd1) nctl = nctl + 1;
    if (reg_rd && reg_wr) nboth = nboth + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %08h expected %08h", req, act, exp);
    end
  endtask

  logic [31:0] res;
  int w0, a0, r0, s0, c0, j0, rs0;

  task automatic run(input logic [1:0] o, input logic [6:0] d, input logic [31:0] ma,
                     input logic [1:0] am, input int n);
    int cyc;
    logic bad;
    w0 = wn; a0 = an; r0 = rn; s0 = stops; c0 = nctl; j0 = tj; rs0 = rstarts;
    @(negedge clk);
    op = o; dev_addr = d; mem_addr = ma; alen_m1 = am; count = 8'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0; bad = 1'b0;
    while (!done && cyc < 5000) begin
      if (!busy) bad = 1'b1;
      @(negedge clk); cyc++;
    end
    if (cyc >= 5000) begin
      errors++; $display("FAIL R9 transfer hung actual none expected done");
    end
    res = result;
    chk("R9 busy held until done", 32'(bad), 32'd0);
    @(negedge clk);
    chk("R9 done one cycle then idle", {30'd0, done, busy}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual expired expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {26'd0, busy, done, reg_wr, reg_rd, in_ready, out_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int am = 0; am < 4; am++)
      for (int n = 0; n < 4; n++) begin
        logic [31:0] ma;
        ma = 32'h1A2B3C4D + 32'(am * 977 + n * 31);
        run(2'd0, DEV, ma, 2'(am), n);
        chk("R2 write result", res, 32'd0);
        chk("R2 write byte count", 32'(wn - w0), 32'(2 + am + n));
        chk("R2 device address write", 32'(wlog[w0]), 32'({DEV, 1'b0}));
        for (int i = 0; i <= am; i++)
          chk("R2 memory address byte msb first", 32'(wlog[w0 + 1 + i]), 32'(8'(ma >> (8 * (am - i)))));
        for (int i = 0; i < n; i++)
          chk("R2 data byte from stream", 32'(wlog[w0 + 2 + am + i]), 32'(txg(j0 + i)));
        chk("R8 one stop per write", 32'(stops - s0), 32'd1);
      end

    for (int am = 0; am < 4; am++)
      for (int n = 1; n < 4; n++) begin
        logic [31:0] ma;
        ma = 32'hF0E1D2C3 - 32'(am * 313 + n);
        run(2'd1, DEV, ma, 2'(am), n);
        chk("R3 read result", res, 32'd0);
        chk("R3 address bytes", 32'(wn - w0), 32'(3 + am));
        chk("R3 device write address", 32'(wlog[w0]), 32'({DEV, 1'b0}));
        for (int i = 0; i <= am; i++)
          chk("R3 memory address byte", 32'(wlog[w0 + 1 + i]), 32'(8'(ma >> (8 * (am - i)))));
        chk("R3 device read address", 32'(wlog[w0 + 2 + am]), 32'({DEV, 1'b1}));
        chk("R3 repeated start without stop", {16'(rstarts - rs0), 16'(stops - s0)}, {16'd1, 16'd1});
        chk("R3 received count", 32'(rn - r0), 32'(n));
        for (int k = 0; k < n; k++) begin
          chk("R3 received byte", 32'(rxlog[r0 + k]), 32'(rxg(k)));
          chk("R10 ack all but last", 32'(acklog[a0 + k]), 32'(k != n - 1));
        end
      end

    run(2'd2, DEV, 32'hFFFF_FFFF, 2'd3, 5);
    chk("R4 probe result", res, 32'd0);
    chk("R4 probe sends only read address", {16'(wn - w0), 8'd0, wlog[w0]}, {16'd1, 8'd0, DEV, 1'b1});
    chk("R4 probe one byte nak", {16'(an - a0), 15'd0, acklog[a0]}, {16'd1, 16'd0});

    run(2'd2, 7'h23, 32'h0, 2'd0, 1);
    chk("R6 probe wrong device", res, 32'h01_48_48_40);
    chk("R8 stop after error", 32'(stops - s0), 32'd1);

    run(2'd1, 7'h11, 32'h55, 2'd1, 2);
    chk("R6 read wrong device", res, 32'h01_48_20_18);
    chk("R6 abort after first address", {16'(wn - w0), 16'(rn - r0)}, {16'd1, 16'd0});

    mute = 1'b1;
    run(2'd0, DEV, 32'h77, 2'd0, 1);
    mute = 1'b0;
    chk("R7 timeout word", res, 32'h02_40_F8_08);
    chk("R5 control polls bounded", 32'(nctl - c0), 32'(PMAX));
    chk("R8 stop after timeout", 32'(stops - s0), 32'd1);

    noidle = 1'b1;
    run(2'd0, DEV, 32'h99, 2'd0, 1);
    noidle = 1'b0;
    chk("R8 missing idle after success", res, 32'h02_40_28_F8);

    run(2'd0, DEV, 32'h1234, 2'd1, 2);
    chk("R8 recovers after idle fault", res, 32'd0);

    chk("R11 no simultaneous access", 32'(nboth), 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule